// File: doc/BRIEF.md
# Left-Justified Stereo Audio Receiver

This block takes a three-wire serial stereo PCM stream (bit clock, frame clock, data line) in left-justified format and turns it into parallel 24-bit left and right samples in the system clock domain. The frame clock is high while the left channel is sent. The first data bit of each channel is the bit present at the first bit-clock rising edge after a frame-clock change, and bits follow MSB first. The word length can change from frame to frame. A word shorter than 24 bits is padded with zeros at the low end. Bits past the 24th are dropped.

All three serial lines pass through two-flop synchronisers. Bit-clock rising edges are found from the registered history of the synchronised bit clock, and the frame clock and data are sampled at those edges. A channel word is closed at the frame-clock change that ends its slot. Once a right word closes after a left word, both are presented together with a one-cycle strobe on each channel. After reset, the block drops the slot that was already under way and any right word that has no left partner. Output starts only with the first complete left-then-right pair.

Top module: `lj_audio_rx`

## Requirements
- R1: A slot sent while the frame clock is high is delivered on `left_o`, and a slot sent while it is low is delivered on `right_o`.
- R2: The bit on the data line at the first bit-clock rising edge after a frame-clock change becomes bit 23 (MSB) of that channel's word, with no one-bit delay.
- R3: Later bits fill bits 22 down to 0 in arrival order, so a 24-bit slot is delivered unchanged.
- R4: If a slot holds N < 24 bits, bits 23..24-N hold the received bits and bits 23-N..0 are zero.
- R5: Bits that arrive after the 24th bit of a slot and before the next frame-clock change have no effect on the delivered word.
- R6: When a right word closes after a left word, `left_o` and `right_o` update together, and `left_vld_o` and `right_vld_o` both pulse high for exactly one cycle.
- R7: While `rst_ni` is low, `left_o` and `right_o` are zero and both strobes are low.
- R8: After reset, nothing is delivered from the slot that was in progress at the first observed bit-clock edge, or from a right word with no complete left word before it. The first strobe follows the first complete left-then-right pair.
- R9: `left_o` and `right_o` hold their values in every cycle without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk_i |
| lrclk_i | input | 1 | Frame clock: high = left, low = right |
| sdata_i | input | 1 | Serial data, MSB first |
| left_o | output | 24 | Left sample, MSB-aligned |
| right_o | output | 24 | Right sample, MSB-aligned |
| left_vld_o | output | 1 | One-cycle strobe for a new left sample |
| right_vld_o | output | 1 | One-cycle strobe for a new right sample |

## Verification
A bit counter that stays stuck or fails to clear at a slot boundary shows up as shifted or corrupted sample bits. This appears at the very next strobe, one frame after the fault. A wrong channel latch or pairing flag shows up as swapped words, a missing strobe or an extra strobe, which the scoreboard reports as a mismatch or as an unexpected item. A wrong start-up filter shows up as a strobe from a partial slot in the first frame after reset.

// File: rtl/lj_rx_pkg.sv
package lj_rx_pkg;
  typedef enum logic {
    CH_RIGHT = 1'b0,
    CH_LEFT  = 1'b1
  } chan_e;
endpackage

// File: rtl/lj_rx_sync.sv
module lj_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else if (s == 0) chain_q[s] <= d_i;
        else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lj_rx_frontend.sv
module lj_rx_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic lrclk_i,
  input  logic sdata_i,
  output logic bit_rise_o,
  output logic lr_o,
  output logic data_o
);
  logic [2:0] raw, synced;
  logic       bclk_hist_q;

  assign raw = {bclk_i, lrclk_i, sdata_i};

  lj_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_hist_q <= 1'b0;
    else         bclk_hist_q <= synced[2];
  end

  // frame clock and data share the bit clock's latency, so they line up at the edge
  assign bit_rise_o = synced[2] & ~bclk_hist_q;
  assign lr_o       = synced[1];
  assign data_o     = synced[0];
endmodule

// File: rtl/lj_rx_shifter.sv
module lj_rx_shifter
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_rise_i,
  input  logic                lr_i,
  input  logic                data_i,
  output logic                commit_o,
  output chan_e               commit_ch_o,
  output logic [SAMPLE_W-1:0] commit_word_o
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(SAMPLE_W);

  logic [SAMPLE_W-1:0] shreg_q;
  logic [CNT_W-1:0]    cnt_q;
  chan_e               cur_ch_q;
  logic                primed_q;   // first bit edge seen, channel known
  logic                in_slot_q;  // current slot began at an observed transition
  logic                change;
  logic [SAMPLE_W-1:0] bit_vec;

  assign change  = primed_q && (chan_e'(lr_i) != cur_ch_q);
  assign bit_vec = {data_i, {(SAMPLE_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q       <= '0;
      cnt_q         <= '0;
      cur_ch_q      <= CH_RIGHT;
      primed_q      <= 1'b0;
      in_slot_q     <= 1'b0;
      commit_o      <= 1'b0;
      commit_ch_o   <= CH_RIGHT;
      commit_word_o <= '0;
    end else begin
      commit_o <= 1'b0;
      if (bit_rise_i) begin
        if (!primed_q) begin
          primed_q <= 1'b1;
          cur_ch_q <= chan_e'(lr_i);
        end else if (change) begin
          if (in_slot_q) begin
            commit_o      <= 1'b1;
            commit_ch_o   <= cur_ch_q;
            commit_word_o <= shreg_q;
          end
          in_slot_q <= 1'b1;
          cur_ch_q  <= chan_e'(lr_i);
          shreg_q   <= bit_vec;
          cnt_q     <= CNT_W'(1);
        end else if (cnt_q < CNT_FULL) begin
          shreg_q <= shreg_q | (bit_vec >> cnt_q);
          cnt_q   <= cnt_q + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lj_rx_pair.sv
module lj_rx_pair
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                commit_i,
  input  chan_e               commit_ch_i,
  input  logic [SAMPLE_W-1:0] commit_word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                left_vld_o,
  output logic                right_vld_o
);
  logic [SAMPLE_W-1:0] left_buf_q;
  logic                left_have_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_buf_q  <= '0;
      left_have_q <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
    end else begin
      left_vld_o  <= 1'b0;
      right_vld_o <= 1'b0;
      if (commit_i) begin
        if (commit_ch_i == CH_LEFT) begin
          left_buf_q  <= commit_word_i;
          left_have_q <= 1'b1;
        end else if (left_have_q) begin
          left_o      <= left_buf_q;
          right_o     <= commit_word_i;
          left_vld_o  <= 1'b1;
          right_vld_o <= 1'b1;
          left_have_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/lj_audio_rx.sv
module lj_audio_rx
  import lj_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_i,
  input  logic                lrclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                left_vld_o,
  output logic                right_vld_o
);
  logic                bit_rise, lr_s, data_s, commit;
  chan_e               commit_ch;
  logic [SAMPLE_W-1:0] commit_word;

  lj_rx_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_frontend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_i     (bclk_i),
    .lrclk_i    (lrclk_i),
    .sdata_i    (sdata_i),
    .bit_rise_o (bit_rise),
    .lr_o       (lr_s),
    .data_o     (data_s)
  );

  lj_rx_shifter #(.SAMPLE_W(SAMPLE_W)) u_shifter (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .bit_rise_i    (bit_rise),
    .lr_i          (lr_s),
    .data_i        (data_s),
    .commit_o      (commit),
    .commit_ch_o   (commit_ch),
    .commit_word_o (commit_word)
  );

  lj_rx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (commit),
    .commit_ch_i   (commit_ch),
    .commit_word_i (commit_word),
    .left_o        (left_o),
    .right_o       (right_o),
    .left_vld_o    (left_vld_o),
    .right_vld_o   (right_vld_o)
  );
endmodule

// File: rtl/lj_audio_rx_checker.sv
module lj_audio_rx_checker #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                lrclk_i,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                left_vld_o,
  input logic                right_vld_o
);
  logic       lr_prev_q;
  logic [1:0] trans_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_prev_q <= lrclk_i;
      trans_q   <= '0;
    end else begin
      lr_prev_q <= lrclk_i;
      if (lrclk_i != lr_prev_q && trans_q != 2'd3) trans_q <= trans_q + 2'd1;
    end
  end

  // R7: cleared outputs while held in reset
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R7: assert (left_o == '0 && right_o == '0 && !left_vld_o && !right_vld_o)
        else $error("outputs not cleared in reset");
    end
  end

  // R6: strobes are single-cycle pulses
  assert_strobe_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_vld_o || right_vld_o) |=> !(left_vld_o || right_vld_o));

  // R9: words hold between strobes
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !left_vld_o |-> ($stable(left_o) && $stable(right_o)));

  // R8: a pair needs three frame-clock transitions after reset
  assert_no_early_pair_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    left_vld_o |-> (trans_q == 2'd3));
endmodule

bind lj_audio_rx lj_audio_rx_checker #(.SAMPLE_W(SAMPLE_W)) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lrclk_i     (lrclk_i),
  .left_o      (left_o),
  .right_o     (right_o),
  .left_vld_o  (left_vld_o),
  .right_vld_o (right_vld_o)
);

// File: tb/lj_audio_rx_bench.sv
module lj_audio_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        left_vld_o, right_vld_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [47:0] exp_q[$];
  logic [23:0] last_l = '0, last_r = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lj_audio_rx u_lj_audio_rx (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .bclk_i      (bclk),
    .lrclk_i     (lrclk),
    .sdata_i     (sdata),
    .left_o      (left_o),
    .right_o     (right_o),
    .left_vld_o  (left_vld_o),
    .right_vld_o (right_vld_o)
  );

  task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] expect_word(input logic [31:0] val, input int n);
    int k;
    k = (n > 24) ? 24 : n;
    return val[31:8] & ~(24'hFFFFFF >> k);
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    @(negedge clk);
    lrclk = lr;
    sdata = d;
    repeat (HALF_BIT) @(negedge clk);
    bclk = 1'b1;
    repeat (HALF_BIT) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_slot(input logic lr, input logic [31:0] val, input int n);
    for (int i = 0; i < n; i++) send_bit(lr, val[31-i]);
  endtask

  task automatic send_pair(input logic [31:0] l, input int ln, input logic [31:0] r, input int rn);
    send_slot(1'b1, l, ln);
    send_slot(1'b0, r, rn);
    exp_q.push_back({expect_word(l, ln), expect_word(r, rn)});
  endtask

  // monitor: pops expected pairs as strobes appear
  always @(negedge clk) begin
    if (rst_ni && !done && (left_vld_o || right_vld_o)) begin
      check(left_vld_o && right_vld_o, "R6 both strobes", {46'd0, left_vld_o, right_vld_o}, 48'd3);
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected pair", {left_o, right_o}, 48'd0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check({left_o, right_o} == e, "R1/R2/R3/R4/R5 pair", {left_o, right_o}, e);
        last_l = left_o;
        last_r = right_o;
      end
    end
  end

  task automatic drain(input string req);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, req, 48'(exp_q.size()), 48'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(left_o == '0 && right_o == '0 && !left_vld_o, "R7 reset state", {left_o, right_o}, 48'd0);
    rst_ni = 1'b1;
    // partial right slot then full frames
    send_slot(1'b0, 32'hFFFF_FFFF, 5);
    send_pair(32'hA5C3_F100, 24, 32'h1234_5600, 24);        // R3 full words, R1 mapping
    send_pair(32'h8001_0000, 16, 32'hFFFF_0000, 16);        // R4 16-bit
    send_pair(32'hBEEF_F000, 20, 32'h0ABC_D000, 20);        // R4 20-bit
    send_pair(32'h7FFF_FFFF, 32, 32'hC3C3_C3FF, 28);        // R5 overlong slots
    send_pair(32'h8000_0000, 1, 32'h0000_0000, 17);         // R2 MSB right at edge
    send_slot(1'b1, 32'hFFFF_FFFF, 6);                      // closes last right
    drain("R6 all pairs delivered");
    // R9: outputs hold while a slot is in progress
    send_slot(1'b1, 32'h5555_5555, 8);
    check(left_o == last_l && right_o == last_r, "R9 hold", {left_o, right_o}, {last_l, last_r});
    check(!left_vld_o, "R9 no strobe mid-slot", 48'(left_vld_o), 48'd0);
    // reset mid-left slot
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(left_o == '0 && right_o == '0 && !left_vld_o && !right_vld_o, "R7 mid-run reset",
          {left_o, right_o}, 48'd0);
    rst_ni = 1'b1;
    // R8: partial left, orphan right, then one real pair
    send_slot(1'b1, 32'hFFFF_FFFF, 7);
    send_slot(1'b0, 32'hDEAD_BE00, 24);
    check(exp_q.size() == 0 && left_o == '0 && right_o == '0, "R8 partial and orphan suppressed",
          {left_o, right_o}, 48'd0);
    send_pair(32'h0F0F_0F00, 24, 32'hF0F0_F000, 18);
    send_slot(1'b1, 32'h0, 3);
    drain("R8 first pair after reset");
    check(last_l == 24'h0F0F0F && last_r == 24'hF0F0C0, "R4 post-reset pair",
          {last_l, last_r}, {24'h0F0F0F, 24'hF0F0C0});
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule